// File: doc/BRIEF.md
# Command-Driven Parallel Flash Model

This block behaves like a small parallel NOR flash device on a synchronous bus. Software reads it like memory in array mode. It changes behaviour by writing command bytes. The low byte of every bus write is decoded as a command. A write-cycle counter with four states then follows multi-write sequences: single-word program, sector erase, buffered program, lock/unlock acknowledge and the query and identifier modes. The data array is a byte-wide register file that comes up fully erased.

Every access moves one full word of `BYTES` bytes. A read returns one of four things, chosen by the last accepted command: the array word, the status byte, an identifier word or a query-table byte. A `read_only` input keeps the array from changing. While it is set, the operations that would change the array report error bits in the status byte instead.

Top module: `flcmd_ctrl`

## Requirements
- R1: After reset every array byte reads 0xFF, the status byte is 0x00, and reads return array data.
- R2: A write of 0x40 or 0x10 from the idle state, followed by one data write, stores that word at the written address. The data write sets status bit 7 (ready) and returns the counter to idle. Reads then return status until 0xFF is written.
- R3: A write of 0x20 from the idle state fills every byte of the sector that holds the address with 0xFF and sets ready. A sector is 2^SECT_SHIFT bytes, aligned. Other sectors are untouched. A following 0xD0 returns the counter to idle.
- R4: 0xE8 from the idle state sets ready. The next write's low CNT_W bits give a count N. The following N+1 writes each store one word at their own address. A 0xD0 after them completes the sequence and returns to idle.
- R5: With `read_only` high, program and buffered data writes set status bit 4 and sector erase sets status bit 5. Ready is still set and the array is unchanged.
- R6: 0x50 clears the status byte and returns to array mode. 0xFF, 0xF0 and 0x00 written in the idle state also return to array mode.
- R7: After 0x70, and while a program, erase, buffered or lock command is the last accepted command, reads return the status byte in bits 7:0. When BYTES exceeds 2, a copy also appears in bits 23:16. All other bits are zero.
- R8: After 0x90, the read index is the address's low byte divided by BYTES. Index 0 returns (ID0<<8)|ID1, index 1 returns (ID2<<8)|ID3, and any other index returns 0.
- R9: After 0x98, the same index selects a query byte. Index 0x10..0x12 returns 0x51, 0x52, 0x59, index 0x27 returns ADDR_W, and indexes above 0x30 return 0. Writes other than 0xFF leave query mode in force.
- R10: 0x60 followed by 0xD0 or 0x01 sets ready and returns to idle. 0x60 followed by any other byte returns to array mode.
- R11: An unrecognised command, or a wrong byte where a confirm is expected, abandons the sequence and returns to array mode with the counter idle.
- R12: A read strobe in cycle N updates `bus_rdata` at the clock edge that ends cycle N. Without a read strobe, `bus_rdata` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| read_only | input | 1 | Blocks array changes and reports errors instead |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 8*BYTES | Write data; low byte is the command |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8*BYTES | Registered read data |

## Verification
The bench builds the block with its defaults: 4-byte words, a 256-byte array and 64-byte sectors. The 4-byte width makes the status copy in bits 23:16 visible. Four sectors let an erase be checked against an untouched neighbour. With 4-byte words the index derived from the address low byte reaches 0x3F, so query reads past the end of the table are reachable. With no override of the identifier parameters, the bench compares against values it computes from the defaults.

// File: rtl/flcmd_pkg.sv
// Shared command codes, status bit positions and state types for the
// command-driven flash model. Assumes 8-bit command bytes.
package flcmd_pkg;

    localparam logic [7:0] CMD_NONE    = 8'h00;
    localparam logic [7:0] CMD_PROG_A  = 8'h10;
    localparam logic [7:0] CMD_ERASE   = 8'h20;
    localparam logic [7:0] CMD_PROG_B  = 8'h40;
    localparam logic [7:0] CMD_CLEAR   = 8'h50;
    localparam logic [7:0] CMD_LOCK    = 8'h60;
    localparam logic [7:0] CMD_STATUS  = 8'h70;
    localparam logic [7:0] CMD_IDENT   = 8'h90;
    localparam logic [7:0] CMD_QUERY   = 8'h98;
    localparam logic [7:0] CMD_BUF     = 8'hE8;
    localparam logic [7:0] CMD_ABORT   = 8'hF0;
    localparam logic [7:0] CMD_ARRAY   = 8'hFF;
    localparam logic [7:0] CMD_CONFIRM = 8'hD0;
    localparam logic [7:0] CMD_UNLOCK1 = 8'h01;

    localparam int ST_READY     = 7;
    localparam int ST_ERASE_ERR = 5;
    localparam int ST_PROG_ERR  = 4;

    typedef enum logic [1:0] {
        CYC_IDLE    = 2'd0,
        CYC_ARG     = 2'd1,
        CYC_DATA    = 2'd2,
        CYC_CONFIRM = 2'd3
    } cyc_e;

    typedef enum logic [1:0] {
        RD_ARRAY  = 2'd0,
        RD_STATUS = 2'd1,
        RD_IDENT  = 2'd2,
        RD_QUERY  = 2'd3
    } rdsel_e;

endpackage

// File: rtl/flcmd_seq.sv
// Command sequencer: decodes the command byte of each write, steps the
// write-cycle counter, keeps the status byte and the buffered-write count,
// and issues one-cycle program/erase strobes to the array.
// Assumes a write and its address are valid in the same cycle as wr_en.
module flcmd_seq
    import flcmd_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             read_only,
    input  logic             wr_en,
    input  logic [7:0]       op,
    input  logic [CNT_W-1:0] cnt_in,
    output logic             prog_en,
    output logic             erase_en,
    output rdsel_e           rd_sel,
    output logic [7:0]       status
);

    cyc_e             cyc, cyc_n;
    logic [7:0]       cmd, cmd_n;
    logic [7:0]       st_n;
    logic [CNT_W-1:0] count, cnt_n;
    logic             go_array;

    // Next-state decode of the write-cycle counter, command and status.
    always_comb begin
        cyc_n    = cyc;
        cmd_n    = cmd;
        st_n     = status;
        cnt_n    = count;
        prog_en  = 1'b0;
        erase_en = 1'b0;
        go_array = 1'b0;
        if (wr_en) begin
            unique case (cyc)
                CYC_IDLE: begin
                    case (op)
                        CMD_PROG_A, CMD_PROG_B, CMD_LOCK, CMD_QUERY: begin
                            cyc_n = CYC_ARG;
                            cmd_n = op;
                        end
                        CMD_ERASE: begin
                            erase_en = !read_only;
                            if (read_only) st_n[ST_ERASE_ERR] = 1'b1;
                            st_n[ST_READY] = 1'b1;
                            cyc_n = CYC_ARG;
                            cmd_n = op;
                        end
                        CMD_BUF: begin
                            st_n[ST_READY] = 1'b1;
                            cyc_n = CYC_ARG;
                            cmd_n = op;
                        end
                        CMD_STATUS, CMD_IDENT: cmd_n = op;
                        CMD_CLEAR: begin
                            st_n     = 8'h00;
                            go_array = 1'b1;
                        end
                        default: go_array = 1'b1;
                    endcase
                end
                CYC_ARG: begin
                    case (cmd)
                        CMD_PROG_A, CMD_PROG_B: begin
                            prog_en = !read_only;
                            if (read_only) st_n[ST_PROG_ERR] = 1'b1;
                            st_n[ST_READY] = 1'b1;
                            cyc_n = CYC_IDLE;
                        end
                        CMD_ERASE, CMD_LOCK: begin
                            if (op == CMD_CONFIRM || (cmd == CMD_LOCK && op == CMD_UNLOCK1)) begin
                                st_n[ST_READY] = 1'b1;
                                cyc_n = CYC_IDLE;
                            end else begin
                                go_array = 1'b1;
                            end
                        end
                        CMD_BUF: begin
                            cnt_n = cnt_in;
                            cyc_n = CYC_DATA;
                        end
                        CMD_QUERY: if (op == CMD_ARRAY) go_array = 1'b1;
                        default: go_array = 1'b1;
                    endcase
                end
                CYC_DATA: begin
                    if (cmd == CMD_BUF) begin
                        prog_en = !read_only;
                        if (read_only) st_n[ST_PROG_ERR] = 1'b1;
                        st_n[ST_READY] = 1'b1;
                        if (count == '0) cyc_n = CYC_CONFIRM;
                        cnt_n = count - 1'b1;
                    end else begin
                        go_array = 1'b1;
                    end
                end
                CYC_CONFIRM: begin
                    if (cmd == CMD_BUF && op == CMD_CONFIRM) begin
                        st_n[ST_READY] = 1'b1;
                        cyc_n = CYC_IDLE;
                    end else begin
                        go_array = 1'b1;
                    end
                end
            endcase
            if (go_array) begin
                cyc_n = CYC_IDLE;
                cmd_n = CMD_NONE;
            end
        end
    end

    // Sequencer state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc    <= CYC_IDLE;
            cmd    <= CMD_NONE;
            status <= 8'h00;
            count  <= '0;
        end else begin
            cyc    <= cyc_n;
            cmd    <= cmd_n;
            status <= st_n;
            count  <= cnt_n;
        end
    end

    // Read source chosen by the last accepted command.
    always_comb begin
        case (cmd)
            CMD_PROG_A, CMD_ERASE, CMD_PROG_B, CMD_CLEAR,
            CMD_LOCK, CMD_STATUS, CMD_BUF: rd_sel = RD_STATUS;
            CMD_IDENT:                     rd_sel = RD_IDENT;
            CMD_QUERY:                     rd_sel = RD_QUERY;
            default:                       rd_sel = RD_ARRAY;
        endcase
    end

    p_confirm_only_buffer_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CYC_CONFIRM) |-> (cmd == CMD_BUF));

    p_prog_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cyc == CYC_ARG && (cmd == CMD_PROG_A || cmd == CMD_PROG_B))
        |=> (cyc == CYC_IDLE && status[ST_READY]));

    p_ro_prog_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && read_only && cyc == CYC_ARG && cmd == CMD_PROG_B)
        |=> status[ST_PROG_ERR]);

    p_clear_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cyc == CYC_IDLE && op == CMD_CLEAR)
        |=> (status == 8'h00 && rd_sel == RD_ARRAY));

    p_unlock_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cyc == CYC_ARG && cmd == CMD_LOCK && op == CMD_UNLOCK1)
        |=> (cyc == CYC_IDLE && status[ST_READY]));

    p_bad_confirm_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cyc == CYC_CONFIRM && op != CMD_CONFIRM)
        |=> (cyc == CYC_IDLE && rd_sel == RD_ARRAY));

endmodule

// File: rtl/flcmd_array.sv
// Byte-wide storage array. Reset fills it with 0xFF. A program strobe
// writes one aligned word in lane order (lane k = bits 8k+7:8k); an erase
// strobe fills the whole aligned sector in one cycle. The read word is
// combinational from the aligned address. Assumes prog_en and erase_en
// are never high together.
module flcmd_array #(
    parameter int ADDR_W     = 8,
    parameter int BYTES      = 4,
    parameter int SECT_SHIFT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [8*BYTES-1:0] wdata,
    input  logic              prog_en,
    input  logic              erase_en,
    output logic [8*BYTES-1:0] rword
);

    localparam int DEPTH      = 1 << ADDR_W;
    localparam int LANE_SHIFT = $clog2(BYTES);
    localparam logic [ADDR_W-1:0] WORD_MASK = ADDR_W'(BYTES - 1);
    localparam logic [ADDR_W-1:0] SECT_MASK = ADDR_W'((1 << SECT_SHIFT) - 1);

    logic [7:0]        mem [DEPTH];
    logic [ADDR_W-1:0] word_base;
    logic [ADDR_W-1:0] sect_base;

    assign word_base = addr & ~WORD_MASK;
    assign sect_base = addr & ~SECT_MASK;

    // Per-byte update: reset, sector fill, or word program.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) begin
                mem[i] <= 8'hFF;
            end else if (erase_en && ((ADDR_W'(i) >> SECT_SHIFT) == (addr >> SECT_SHIFT))) begin
                mem[i] <= 8'hFF;
            end else if (prog_en && ((ADDR_W'(i) >> LANE_SHIFT) == (addr >> LANE_SHIFT))) begin
                mem[i] <= wdata[8*(i % BYTES) +: 8];
            end
        end
    end

    // Assemble the read word lane by lane.
    for (genvar k = 0; k < BYTES; k++) begin : g_lane
        assign rword[8*k +: 8] = mem[word_base + ADDR_W'(k)];
    end

    p_erase_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        erase_en |=> (mem[$past(sect_base)] == 8'hFF));

    p_prog_lane0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |=> (mem[$past(word_base)] == $past(wdata[7:0])));

endmodule

// File: rtl/flcmd_info.sv
// Identifier and query lookup. The index is the address low byte divided
// by the word width. Assumes ADDR_W >= 8. Purely combinational.
module flcmd_info #(
    parameter int          ADDR_W     = 8,
    parameter int          BYTES      = 4,
    parameter int          SECT_SHIFT = 6,
    parameter int          CNT_W      = 8,
    parameter logic [15:0] ID0        = 16'h0089,
    parameter logic [15:0] ID1        = 16'h0018,
    parameter logic [15:0] ID2        = 16'h0000,
    parameter logic [15:0] ID3        = 16'h0017
) (
    input  logic [7:0]         addr_lo,
    output logic [8*BYTES-1:0] ident_word,
    output logic [7:0]         query_byte
);

    localparam int LANE_SHIFT = $clog2(BYTES);
    localparam int NSECT      = 1 << (ADDR_W - SECT_SHIFT);
    localparam int SECT_BYTES = 1 << SECT_SHIFT;
    localparam logic [7:0] QRY_LAST = 8'h30;
    localparam logic [23:0] ID_HI = (24'(ID0) << 8) | 24'(ID1);
    localparam logic [23:0] ID_LO = (24'(ID2) << 8) | 24'(ID3);

    logic [7:0] idx;
    assign idx = addr_lo >> LANE_SHIFT;

    // Query table entries, computed from the geometry parameters.
    function automatic logic [7:0] qry_entry(input logic [7:0] i);
        case (i)
            8'h10:   return 8'h51;
            8'h11:   return 8'h52;
            8'h12:   return 8'h59;
            8'h13:   return 8'h01;
            8'h15:   return 8'h31;
            8'h27:   return 8'(ADDR_W);
            8'h28:   return 8'h02;
            8'h2A:   return 8'(CNT_W);
            8'h2C:   return 8'h01;
            8'h2D:   return 8'(NSECT - 1);
            8'h2E:   return 8'((NSECT - 1) >> 8);
            8'h2F:   return 8'(SECT_BYTES >> 8);
            8'h30:   return 8'(SECT_BYTES >> 16);
            default: return 8'h00;
        endcase
    endfunction

    // Identifier word by index.
    always_comb begin
        case (idx)
            8'd0:    ident_word = (8*BYTES)'(ID_HI);
            8'd1:    ident_word = (8*BYTES)'(ID_LO);
            default: ident_word = '0;
        endcase
    end

    // Query byte, zero past the end of the table.
    assign query_byte = (idx > QRY_LAST) ? 8'h00 : qry_entry(idx);

endmodule

// File: rtl/flcmd_ctrl.sv
// Top of the command-driven flash model. Routes the write to the sequencer
// and array, and registers the read word chosen by the sequencer's read
// source. Assumes word-aligned addresses and CNT_W <= 8*BYTES, ADDR_W >= 8.
module flcmd_ctrl
    import flcmd_pkg::*;
#(
    parameter int          BYTES      = 4,
    parameter int          ADDR_W     = 8,
    parameter int          SECT_SHIFT = 6,
    parameter int          CNT_W      = 8,
    parameter logic [15:0] ID0        = 16'h0089,
    parameter logic [15:0] ID1        = 16'h0018,
    parameter logic [15:0] ID2        = 16'h0000,
    parameter logic [15:0] ID3        = 16'h0017
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 read_only,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [8*BYTES-1:0]   bus_wdata,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    output logic [8*BYTES-1:0]   bus_rdata
);

    localparam int DW = 8 * BYTES;

    logic          prog_en;
    logic          erase_en;
    rdsel_e        rd_sel;
    logic [7:0]    status;
    logic [DW-1:0] array_word;
    logic [DW-1:0] ident_word;
    logic [7:0]    query_byte;
    logic [DW-1:0] status_word;
    logic [DW-1:0] rmux;

    flcmd_seq #(.CNT_W(CNT_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .read_only(read_only),
        .wr_en    (bus_wr),
        .op       (bus_wdata[7:0]),
        .cnt_in   (bus_wdata[CNT_W-1:0]),
        .prog_en  (prog_en),
        .erase_en (erase_en),
        .rd_sel   (rd_sel),
        .status   (status)
    );

    flcmd_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .SECT_SHIFT(SECT_SHIFT)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .prog_en (prog_en),
        .erase_en(erase_en),
        .rword   (array_word)
    );

    flcmd_info #(
        .ADDR_W(ADDR_W), .BYTES(BYTES), .SECT_SHIFT(SECT_SHIFT), .CNT_W(CNT_W),
        .ID0(ID0), .ID1(ID1), .ID2(ID2), .ID3(ID3)
    ) u_info (
        .addr_lo   (bus_addr[7:0]),
        .ident_word(ident_word),
        .query_byte(query_byte)
    );

    // Status word: copy in bits 23:16 only on words wider than two bytes.
    if (BYTES > 2) begin : g_status_wide
        assign status_word = DW'({status, 16'h0000}) | DW'(status);
    end else begin : g_status_narrow
        assign status_word = DW'(status);
    end

    // Select the read source.
    always_comb begin
        unique case (rd_sel)
            RD_ARRAY:  rmux = array_word;
            RD_STATUS: rmux = status_word;
            RD_IDENT:  rmux = ident_word;
            RD_QUERY:  rmux = DW'(query_byte);
        endcase
    end

    // One-cycle registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rmux;
    end

    p_read_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    p_status_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && rd_sel == RD_STATUS) |=> (bus_rdata[15:8] == 8'h00));

endmodule

// File: tb/flcmd_ctrl_bench.sv
`timescale 1ns/1ps
module flcmd_ctrl_bench;

    localparam int          BYTES = 4;
    localparam int          AW    = 8;
    localparam logic [15:0] ID0   = 16'h0089;
    localparam logic [15:0] ID1   = 16'h0018;
    localparam logic [15:0] ID2   = 16'h0000;
    localparam logic [15:0] ID3   = 16'h0017;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          read_only = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [31:0]   bus_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    flcmd_ctrl u_flcmd_ctrl (
        .clk(clk), .rst_n(rst_n), .read_only(read_only),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(8'h00, v); check("R1 erased at 0x00", v, 32'hFFFF_FFFF);
        rd(8'hFC, v); check("R1 erased at 0xFC", v, 32'hFFFF_FFFF);
        wr(8'h00, 32'h70);
        rd(8'h00, v); check("R1 status zero", v, 32'h0);
        wr(8'h00, 32'hFF);
    endtask

    task automatic t_program;
        logic [31:0] v;
        wr(8'h10, 32'h40);
        wr(8'h10, 32'h1122_3344);
        rd(8'h10, v); check("R2 R7 status after program", v, 32'h0080_0080);
        wr(8'h00, 32'hFF);
        rd(8'h10, v); check("R2 programmed word", v, 32'h1122_3344);
        wr(8'h44, 32'h10);
        wr(8'h44, 32'hCAFE_F00D);
        wr(8'h80, 32'h40);
        wr(8'h80, 32'h0BAD_BEEF);
        wr(8'h00, 32'hFF);
        rd(8'h44, v); check("R2 second opcode", v, 32'hCAFE_F00D);
    endtask

    task automatic t_erase;
        logic [31:0] v;
        wr(8'h00, 32'h50);
        wr(8'h48, 32'h20);
        rd(8'h48, v); check("R3 R7 status during erase", v, 32'h0080_0080);
        wr(8'h48, 32'hD0);
        wr(8'h00, 32'hFF);
        rd(8'h44, v); check("R3 erased inside sector", v, 32'hFFFF_FFFF);
        rd(8'h80, v); check("R3 next sector kept", v, 32'h0BAD_BEEF);
        rd(8'h10, v); check("R3 lower sector kept", v, 32'h1122_3344);
    endtask

    task automatic t_buffer;
        logic [31:0] v;
        wr(8'h00, 32'h50);
        wr(8'h20, 32'hE8);
        wr(8'h20, 32'd2);
        wr(8'h20, 32'hA0A0_0001);
        wr(8'h24, 32'hA0A0_0002);
        wr(8'h28, 32'hA0A0_0003);
        wr(8'h20, 32'hD0);
        rd(8'h20, v); check("R4 status after confirm", v, 32'h0080_0080);
        wr(8'h00, 32'hFF);
        rd(8'h20, v); check("R4 word 0", v, 32'hA0A0_0001);
        rd(8'h24, v); check("R4 word 1", v, 32'hA0A0_0002);
        rd(8'h28, v); check("R4 word 2", v, 32'hA0A0_0003);
        rd(8'h2C, v); check("R4 no extra word", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_read_only;
        logic [31:0] v;
        @(negedge clk); read_only = 1'b1;
        wr(8'h00, 32'h50);
        wr(8'h10, 32'h40);
        wr(8'h10, 32'hDEAD_BEEF);
        rd(8'h10, v); check("R5 program error bit", v, 32'h0090_0090);
        wr(8'h00, 32'hFF);
        wr(8'h00, 32'h50);
        wr(8'h10, 32'h20);
        rd(8'h10, v); check("R5 erase error bit", v, 32'h00A0_00A0);
        wr(8'h10, 32'hD0);
        wr(8'h00, 32'hFF);
        rd(8'h10, v); check("R5 array unchanged", v, 32'h1122_3344);
        @(negedge clk); read_only = 1'b0;
    endtask

    task automatic t_clear_and_exit;
        logic [31:0] v;
        wr(8'h00, 32'h50);
        rd(8'h10, v); check("R6 clear returns to array", v, 32'h1122_3344);
        wr(8'h00, 32'h70);
        rd(8'h10, v); check("R6 status cleared", v, 32'h0);
        wr(8'h00, 32'hF0);
        rd(8'h10, v); check("R6 0xF0 returns to array", v, 32'h1122_3344);
        wr(8'h00, 32'h70);
        wr(8'h00, 32'h00);
        rd(8'h10, v); check("R6 0x00 returns to array", v, 32'h1122_3344);
    endtask

    task automatic t_ident;
        logic [31:0] v;
        wr(8'h00, 32'h90);
        rd(8'h00, v); check("R8 index 0", v, (32'(ID0) << 8) | 32'(ID1));
        rd(8'h04, v); check("R8 index 1", v, (32'(ID2) << 8) | 32'(ID3));
        rd(8'h08, v); check("R8 other index", v, 32'h0);
        wr(8'h00, 32'hFF);
    endtask

    task automatic t_query;
        logic [31:0] v;
        wr(8'h00, 32'h98);
        rd(8'h40, v); check("R9 index 0x10", v, 32'h51);
        rd(8'h44, v); check("R9 index 0x11", v, 32'h52);
        wr(8'h00, 32'h12);
        rd(8'h48, v); check("R9 query held after other write", v, 32'h59);
        rd(8'h9C, v); check("R9 size index", v, 32'(AW));
        rd(8'hFC, v); check("R9 beyond table", v, 32'h0);
        wr(8'h00, 32'hFF);
        rd(8'h10, v); check("R9 0xFF leaves query", v, 32'h1122_3344);
    endtask

    task automatic t_lock;
        logic [31:0] v;
        wr(8'h00, 32'h50);
        wr(8'h00, 32'h60);
        wr(8'h00, 32'h01);
        rd(8'h00, v); check("R10 unlock acknowledged", v, 32'h0080_0080);
        wr(8'h00, 32'h50);
        wr(8'h00, 32'h60);
        wr(8'h00, 32'hD0);
        rd(8'h00, v); check("R10 lock acknowledged", v, 32'h0080_0080);
        wr(8'h00, 32'h60);
        wr(8'h00, 32'h33);
        rd(8'h10, v); check("R10 bad second byte", v, 32'h1122_3344);
    endtask

    task automatic t_unknown;
        logic [31:0] v;
        wr(8'h00, 32'h70);
        wr(8'h00, 32'h77);
        rd(8'h10, v); check("R11 unknown command", v, 32'h1122_3344);
        wr(8'h30, 32'hE8);
        wr(8'h30, 32'd0);
        wr(8'h30, 32'h5555_6666);
        wr(8'h30, 32'h12);
        rd(8'h30, v); check("R11 bad confirm to array", v, 32'h5555_6666);
    endtask

    task automatic t_latency;
        logic [31:0] v;
        rd(8'h80, v); check("R12 first read", v, 32'h0BAD_BEEF);
        @(negedge clk);
        bus_addr = 8'h10; bus_rd = 1'b1;
        #0.5; check("R12 before edge", bus_rdata, 32'h0BAD_BEEF);
        @(negedge clk);
        bus_rd = 1'b0;
        check("R12 after edge", bus_rdata, 32'h1122_3344);
        bus_addr = 8'h80;
        @(negedge clk);
        check("R12 held without strobe", bus_rdata, 32'h1122_3344);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 read data after reset", bus_rdata, 32'h0);
        t_reset();
        t_program();
        t_erase();
        t_buffer();
        t_read_only();
        t_clear_and_exit();
        t_ident();
        t_query();
        t_lock();
        t_unknown();
        t_latency();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule